// File: doc/BRIEF.md
# PLL Divider Chain with Test Output Selector

This block holds the digital counters that sit around a frequency synthesizer loop. It divides a reference clock by a fixed 16, divides the oscillator clock by a programmable 9-bit ratio to make the loop feedback, and divides the oscillator clock again by 1, 2, 4 or 8 to make the synthesizer output. The output always has a 50% duty cycle. A second copy of the programmable ratio divides the serial configuration clock. An eight-way selector routes one of these internal signals, or a constant, to a single test pin.

The design runs on one system clock, and every modelled clock arrives as a one-cycle enable. `ref_tick` and `sclk_tick` mark the rising edges of the reference clock and the serial clock. `vco_edge` marks every edge of the oscillator clock, both rising and falling, so the output divider can produce a true 50% duty cycle even at ratio 1. The first `vco_edge` after reset is a rising edge. A new divide ratio is taken up only when the counter that uses it wraps, so a change in the middle of a period never shortens a pulse.

Top module: `synth_div_mux`

## Requirements
- R1: `ref_div` is low after reset and toggles on every 8th `ref_tick`, which gives a period of 16 ticks with a 50% duty cycle.
- R2: The oscillator rising edges are the odd-numbered `vco_edge` pulses counted from reset. `fb_div` is low after reset. It goes high on the rising edge at which the feedback counter wraps, and goes low on the next rising edge. The first wrap after reset comes on the 511th rising edge.
- R3: Each feedback period lasts M rising edges, where M is the value of `m_val` present on the rising edge that started the period. A change to `m_val` in the middle of a period does not alter that period. Values below 250 are applied as given.
- R4: `m_low` is 1 exactly while `m_val` is below 250, in the same cycle.
- R5: `fout` toggles every N `vco_edge` pulses, so each half period is N edges long. The `n_code` encoding is 00 for N=1, 01 for N=2, 10 for N=4 and 11 for N=8. After reset the ratio is 8 and `fout` is low. The code present on a toggle edge sets the length of the half period that follows it.
- R6: While `out_en` is 0, `fout` is 0 and `fout_n` is 1. While `out_en` is 1, `fout_n` is the inverse of `fout`. Division continues while the output is disabled.
- R7: `test_out` follows `test_code` in the same cycle, as follows: 000 gives `sr_in`, 001 gives 1, 010 gives `ref_div`, 011 gives `fb_div`, 100 gives the ungated synthesizer output, and 101 gives 0.
- R8: With `test_code` 110, `test_out` is the serial clock divided by M. It is high for one `sclk_tick` interval in every M ticks. This divider loads its own copy of `m_val` when it wraps, and its first wrap after reset comes on the 511th tick.
- R9: With `test_code` 111, `test_out` is the synthesizer output divided by 4. It toggles on every second rising edge of the ungated output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference clock rising-edge enable |
| vco_edge | input | 1 | Oscillator edge enable, one pulse for each rising and each falling edge |
| sclk_tick | input | 1 | Serial clock rising-edge enable |
| m_val | input | 9 | Feedback divide ratio |
| n_code | input | 2 | Output divide code |
| test_code | input | 3 | Test output select |
| out_en | input | 1 | Output enable |
| sr_in | input | 1 | Shift-register serial output, routed to the test pin |
| ref_div | output | 1 | Reference divided by 16 |
| fb_div | output | 1 | Feedback divider pulse |
| fout | output | 1 | Synthesizer output, true side |
| fout_n | output | 1 | Synthesizer output, complement side |
| test_out | output | 1 | Selected test signal |
| m_low | output | 1 | Feedback ratio below 250 |

## Verification
`ref_div`, `fb_div` and the internal output toggle are registered. Each of them changes on the clock edge that consumes the tick that causes the change. `fout`, `fout_n`, `test_out` and `m_low` follow their inputs combinationally in the same cycle. The bench drives inputs at the falling clock edge. At each later falling edge it first credits the ticks that the previous rising edge consumed, and then compares every output with the value its own tick counts predict. Only after that does it drive new inputs. Period lengths are counted in ticks between observed transitions. The ratio for each period is taken from the input value held on the edge that started that period. Measurements are dropped while the output is disabled, and also just after the test code switches, until a transition shows that the new ratio has taken effect.

// File: rtl/synth_div_mux.sv
`timescale 1ns/1ps
module synth_div_mux #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int RW = 4,
  parameter int M_MIN = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          vco_edge,
  input  logic          sclk_tick,
  input  logic [MW-1:0] m_val,
  input  logic [NW-1:0] n_code,
  input  logic [2:0]    test_code,
  input  logic          out_en,
  input  logic          sr_in,
  output logic          ref_div,
  output logic          fb_div,
  output logic          fout,
  output logic          fout_n,
  output logic          test_out,
  output logic          m_low
);
  localparam int NMAX = 1 << ((1 << NW) - 1);
  localparam int HW = (NMAX > 1) ? $clog2(NMAX) : 1;
  localparam logic [MW-1:0] ONE_M = MW'(1);
  localparam logic [HW-1:0] ONE_H = HW'(1);

  function automatic logic [HW-1:0] last_of(input logic [NW-1:0] c);
    logic [HW-1:0] v;
    v = '0;
    for (int i = 0; i < HW; i++)
      if (i < int'(c)) v[i] = 1'b1;
    return v;
  endfunction

  logic [RW-1:0] rcnt;
  logic          vph;
  logic [MW-1:0] mcnt, m_act;
  logic          fb_q;
  logic [MW-1:0] scnt, sm_act;
  logic          sq;
  logic [HW-1:0] hcnt;
  logic [NW-1:0] n_act;
  logic          fq, f4c, f4;
  logic          vrise;

  assign vrise = vco_edge & ~vph;

  always_ff @(posedge clk) begin
    if (!rst_n) rcnt <= '0;
    else if (ref_tick) rcnt <= rcnt + RW'(1);
  end
  assign ref_div = rcnt[RW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vph   <= 1'b0;
      mcnt  <= '0;
      m_act <= '1;
      fb_q  <= 1'b0;
    end else begin
      if (vco_edge) vph <= ~vph;
      if (vrise) begin
        if (mcnt == m_act - ONE_M) begin
          mcnt  <= '0;
          m_act <= m_val;
          fb_q  <= 1'b1;
        end else begin
          mcnt <= mcnt + ONE_M;
          fb_q <= 1'b0;
        end
      end
    end
  end
  assign fb_div = fb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt   <= '0;
      sm_act <= '1;
      sq     <= 1'b0;
    end else if (sclk_tick) begin
      if (scnt == sm_act - ONE_M) begin
        scnt   <= '0;
        sm_act <= m_val;
        sq     <= 1'b1;
      end else begin
        scnt <= scnt + ONE_M;
        sq   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt  <= '0;
      n_act <= '1;
      fq    <= 1'b0;
      f4c   <= 1'b0;
      f4    <= 1'b0;
    end else if (vco_edge) begin
      if (hcnt == last_of(n_act)) begin
        hcnt  <= '0;
        n_act <= n_code;
        fq    <= ~fq;
        if (!fq) begin
          f4c <= ~f4c;
          if (f4c) f4 <= ~f4;
        end
      end else begin
        hcnt <= hcnt + ONE_H;
      end
    end
  end

  assign fout   = out_en & fq;
  assign fout_n = ~fout;
  assign m_low  = m_val < MW'(M_MIN);

  always_comb begin
    case (test_code)
      3'b000:  test_out = sr_in;
      3'b001:  test_out = 1'b1;
      3'b010:  test_out = ref_div;
      3'b011:  test_out = fb_q;
      3'b100:  test_out = fq;
      3'b101:  test_out = 1'b0;
      3'b110:  test_out = sq;
      default: test_out = f4;
    endcase
  end
endmodule

// File: rtl/synth_div_mux_chk.sv
`timescale 1ns/1ps
module synth_div_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic       vco_edge,
  input logic       sclk_tick,
  input logic [2:0] test_code,
  input logic       out_en,
  input logic       ref_div,
  input logic       fb_div,
  input logic       fout,
  input logic       fout_n,
  input logic       test_out
);
  assert_ref_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(ref_div));
  assert_fb_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_edge |=> $stable(fb_div));
  assert_fout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vco_edge && out_en) |=> (!out_en || $stable(fout)));
  assert_oe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!fout && fout_n));
  assert_compl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (fout_n != fout));
  assert_mux_fb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'b011) |-> (test_out == fb_div));
  assert_mux_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'b101) |-> !test_out);
  assert_serial_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'b110 && !sclk_tick) |=> (test_code != 3'b110 || $stable(test_out)));
endmodule

bind synth_div_mux synth_div_mux_chk i_chk (.*);

// File: tb/test_synth_div_mux.sv
`timescale 1ns/1ps
module test_synth_div_mux;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ref_tick, vco_edge, sclk_tick, out_en, sr_in;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] test_code;
  logic ref_div, fb_div, fout, fout_n, test_out, m_low;

  synth_div_mux i_synth_div_mux (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_edge(vco_edge),
    .sclk_tick(sclk_tick), .m_val(m_val), .n_code(n_code), .test_code(test_code),
    .out_en(out_en), .sr_in(sr_in), .ref_div(ref_div), .fb_div(fb_div),
    .fout(fout), .fout_n(fout_n), .test_out(test_out), .m_low(m_low)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int bph, rises, exp_m, ref_cnt, edges, exp_half;
  bit prev_fb, prev_ref, armed, prev_fout, prev_en, prev_t;
  int mon_mode, mon_cnt, mon_nt, mon_hi, mon_lo;
  int vco_p = 80, ref_p = 40, sclk_p = 50;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input logic [1:0] c);
    return 1 << c;
  endfunction

  task automatic observe();
    if (vco_edge) begin
      if (bph == 0) rises++;
      bph ^= 1;
      edges++;
    end
    if (ref_tick) ref_cnt++;
    if (ref_div != prev_ref) begin
      chk(ref_cnt == 8, "R1 ref half period", ref_cnt, 8);
      ref_cnt = 0;
    end
    prev_ref = ref_div;
    if (fb_div && !prev_fb) begin
      chk(rises == exp_m, "R2 R3 feedback period", rises, exp_m);
      exp_m = int'(m_val);
      rises = 0;
    end
    if (!fb_div && prev_fb) chk(rises == 1, "R2 feedback high width", rises, 1);
    prev_fb = fb_div;
    chk(m_low == (m_val < 9'd250), "R4 m_low flag", int'(m_low), int'(m_val < 9'd250));
    if (!out_en) chk(!fout && fout_n, "R6 disabled level", int'({fout, fout_n}), 1);
    else chk(fout_n == ~fout, "R6 complement", int'(fout_n), int'(~fout));
    if (out_en && prev_en && fout != prev_fout) begin
      if (armed) chk(edges == exp_half, "R5 half period", edges, exp_half);
      exp_half = ratio(n_code);
      edges = 0;
      armed = 1;
    end else if (out_en && !prev_en) armed = 0;
    prev_fout = fout;
    prev_en = out_en;
    case (test_code)
      3'd0: chk(test_out == sr_in, "R7 select 000", int'(test_out), int'(sr_in));
      3'd1: chk(test_out == 1'b1, "R7 select 001", int'(test_out), 1);
      3'd2: chk(test_out == ref_div, "R7 select 010", int'(test_out), int'(ref_div));
      3'd3: chk(test_out == fb_div, "R7 select 011", int'(test_out), int'(fb_div));
      3'd4: if (out_en) chk(test_out == fout, "R7 select 100", int'(test_out), int'(fout));
      3'd5: chk(test_out == 1'b0, "R7 select 101", int'(test_out), 0);
      default: ;
    endcase
    if (mon_mode == 1 && sclk_tick) mon_cnt++;
    if (mon_mode == 2 && vco_edge) mon_cnt++;
    if (mon_mode != 0 && test_out != prev_t) begin
      mon_nt++;
      if (mon_nt >= 4)
        chk(mon_cnt == (test_out ? mon_lo : mon_hi),
            mon_mode == 1 ? "R8 serial divide" : "R9 output divide by 4",
            mon_cnt, test_out ? mon_lo : mon_hi);
      mon_cnt = 0;
    end
    prev_t = test_out;
  endtask

  task automatic step();
    @(negedge clk);
    observe();
    vco_edge  = ($urandom % 100) < vco_p;
    ref_tick  = ($urandom % 100) < ref_p;
    sclk_tick = ($urandom % 100) < sclk_p;
    sr_in     = $urandom % 2;
  endtask

  task automatic pick_m();
    int r = $urandom % 8;
    if (r == 0) m_val = 9'(250 + $urandom % 12);
    else if (r == 1) m_val = 9'(240 + $urandom % 10);
    else m_val = 9'(3 + $urandom % 10);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ref_tick = 0; vco_edge = 0; sclk_tick = 0;
    out_en = 1; sr_in = 0; m_val = 9'd5; n_code = 2'd0; test_code = 3'd0;
    repeat (3) @(negedge clk);
    chk(ref_div == 0, "R1 reset ref_div", int'(ref_div), 0);
    chk(fb_div == 0, "R2 reset fb_div", int'(fb_div), 0);
    chk(fout == 0, "R5 reset fout", int'(fout), 0);
    chk(fout_n == 1, "R6 reset fout_n", int'(fout_n), 1);
    chk(test_out == sr_in, "R7 reset select", int'(test_out), int'(sr_in));
    rst_n = 1;
    bph = 0; rises = 0; exp_m = 511; ref_cnt = 0; edges = 0; exp_half = 8;
    prev_fb = 0; prev_ref = 0; armed = 1; prev_fout = 0; prev_en = 1; prev_t = 0;
    mon_mode = 0; mon_cnt = 0; mon_nt = 0;

    for (int i = 0; i < 3000; i++) begin
      step();
      if ($urandom % 40 == 0) pick_m();
      if ($urandom % 30 == 0) n_code = 2'($urandom % 4);
      if ($urandom % 25 == 0) test_code = 3'($urandom % 6);
    end

    for (int i = 0; i < 800; i++) begin
      step();
      if ($urandom % 15 == 0) out_en = ~out_en;
      if ($urandom % 30 == 0) n_code = 2'($urandom % 4);
      if ($urandom % 20 == 0) test_code = ($urandom % 2) ? 3'd4 : 3'd1;
    end
    out_en = 1;

    step();
    test_code = 3'd6; m_val = 9'd6; sclk_p = 60;
    mon_mode = 1; mon_cnt = 0; mon_nt = 0; mon_hi = 1; mon_lo = 5;
    for (int i = 0; i < 1500; i++) step();

    step();
    test_code = 3'd7; n_code = 2'd1;
    mon_mode = 2; mon_cnt = 0; mon_nt = 0; mon_hi = 8; mon_lo = 8;
    for (int i = 0; i < 1200; i++) step();

    done = 1;
    summary();
    $finish;
  end
endmodule